// File: doc/BRIEF.md
# Dual Field-Masked Calendar Alarm

This block watches a running calendar (second, minute, hour, date, month and weekday, all in BCD) and compares it against two independent alarm sets. Each alarm set holds six bytes laid out like the matching time field. The top bit of each byte decides whether that field takes part in the comparison. A comparison is made only when the time advances, which the timekeeper signals with a strobe. When every enabled field of an alarm equals the current time, that alarm raises its status flag.

The two alarms share one active-low interrupt line. A single mode bit selects how that line behaves for both alarms. In level mode the line stays low while either flag is set. In pulse mode each match drives the line low for a fixed number of reference ticks; with the default parameter and a 1 kHz tick this is 250 ms. The host can only clear a flag, never set one. It clears a flag by writing 0 to its status bit, or by turning on the auto-clear option, which clears both flags when a status read finishes with a valid stop.

The timekeeper and the serial bus sit outside this block. The block receives already-decoded register writes, a strobe that marks the end of a status read, and a reference tick used to time the pulse.

Top module: `dual_alarm`

## Requirements
- R1: After reset both flags are 0, `irq_n` is 1, every field-enable bit and every control bit is 0, and the date and month alarm bytes hold 01h.
- R2: An alarm matches on a rising edge of `tick_adv` when every one of its fields with bit 7 set has bits [6:0] equal to the current time field. Its flag reads 1 from the cycle after that edge.
- R3: A field whose bit 7 is 0 takes no part in the match: a different value in that time field does not stop the match.
- R4: An alarm with no field-enable bit set never matches.
- R5: An alarm whose master enable is 0 (control bit 0 for alarm A, bit 1 for alarm B) never sets its flag or pulls `irq_n` low.
- R6: Each rising edge of `tick_adv` gives at most one trigger per alarm. Holding `tick_adv` high does not trigger again.
- R7: A write to the status address (17) with bit 0 at 0 clears flag A, and with bit 1 at 0 clears flag B. Writing 1 to a bit leaves that flag unchanged and can never set it.
- R8: In level mode (control bit 2 = 0), `irq_n` is 0 while either flag is 1, and returns to 1 only when both flags are 0.
- R9: In pulse mode (control bit 2 = 1), a match sets the flag and drives `irq_n` low for exactly `PULSE_TICKS` `ref_tick` pulses. After that `irq_n` returns to 1 even though the flag stays set.
- R10: A new match while a pulse is running restarts the pulse at its full length.
- R11: When auto-clear (control bit 3) is 1, a `stat_rd_done` strobe clears both flags on the next cycle. When auto-clear is 0, the strobe has no effect.
- R12: A flag that a match sets in the same cycle as an auto-clearing `stat_rd_done` stays set.
- R13: The two alarms are independent. Alarm A's bytes sit at addresses 0 to 5 and alarm B's at 8 to 13, in the order second, minute, hour, date, month, weekday, and a match of one alarm leaves the other's flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_sec | input | 7 | Current second, BCD |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 7 | Current hour, BCD (including the AM/PM bit if used) |
| cur_date | input | 7 | Current date, BCD |
| cur_month | input | 7 | Current month, BCD |
| cur_wday | input | 7 | Current weekday, 0 to 6 |
| tick_adv | input | 1 | High when the time has advanced; the rising edge qualifies a match |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register write address |
| reg_wdata | input | 8 | Register write data |
| stat_rd_done | input | 1 | One-cycle strobe: a status read has ended with a valid stop |
| ref_tick | input | 1 | Reference tick that times the pulse |
| flag_a | output | 1 | Alarm A status flag |
| flag_b | output | 1 | Alarm B status flag |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
The assertions assume three things about the inputs. The time fields are stable and valid in the cycle in which `tick_adv` rises. `stat_rd_done` is a single-cycle strobe. The mode bit does not change in the same cycle as a match. The stimulus keeps to these rules: every input is driven at the falling clock edge, and each strobe is held for one cycle unless a scenario holds `tick_adv` high on purpose to test edge qualification. Control writes are always separated from advance strobes, so no pulse starts in the same cycle as a mode change.

// File: rtl/alm_pkg.sv
// Package: shared sizes, register addresses and the control word for the
// dual alarm unit. Assumes two alarms of six BCD field bytes each.
package alm_pkg;
    localparam int NUM_ALARMS   = 2;
    localparam int NUM_FIELDS   = 6;
    localparam int ADDR_W       = 5;
    localparam int FIELD_W      = 7;
    localparam int ALARM_STRIDE = 8;
    localparam int ADDR_CTL     = 16;
    localparam int ADDR_STAT    = 17;

    // Field order inside one alarm set; also the byte order in the map.
    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DATE  = 3'd3,
        FLD_MONTH = 3'd4,
        FLD_WDAY  = 3'd5
    } field_e;

    // Control word bit positions.
    localparam int CTL_EN_A   = 0;
    localparam int CTL_EN_B   = 1;
    localparam int CTL_PULSE  = 2;
    localparam int CTL_AUTOCL = 3;

    typedef struct packed {
        logic                  auto_clr;
        logic                  pulse_mode;
        logic [NUM_ALARMS-1:0] alm_en;
    } ctl_t;
endpackage

// File: rtl/alm_regs.sv
// Module: alm_regs
// Holds the alarm field bytes and the control word, written through a
// plain address/data strobe. Also turns writes to the status address into
// a clear-request pulse with a per-alarm keep mask.
// Assumes: one write per cycle; writes to unmapped addresses are dropped.
module alm_regs
    import alm_pkg::*;
#(
    parameter int N_ALM = NUM_ALARMS,
    parameter int N_FLD = NUM_FIELDS,
    parameter int AW    = ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [AW-1:0]                 addr,
    input  logic [7:0]                    wdata,
    output logic [N_ALM-1:0][N_FLD-1:0][7:0] cfg,
    output ctl_t                          ctl,
    output logic                          stat_wr,
    output logic [N_ALM-1:0]              stat_keep
);
    localparam logic [AW-1:0] A_CTL  = AW'(ADDR_CTL);
    localparam logic [AW-1:0] A_STAT = AW'(ADDR_STAT);

    for (genvar a = 0; a < N_ALM; a++) begin : g_alm
        for (genvar f = 0; f < N_FLD; f++) begin : g_fld
            localparam logic [AW-1:0] MY_ADDR = AW'(a * ALARM_STRIDE + f);
            // Date and month bytes start at 01h, the rest at 00h.
            localparam logic [7:0] RST_VAL =
                (f == int'(FLD_DATE) || f == int'(FLD_MONTH)) ? 8'h01 : 8'h00;

            // Purpose: capture a host write to this field byte.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cfg[a][f] <= RST_VAL;
                else if (we && addr == MY_ADDR)
                    cfg[a][f] <= wdata;
            end
        end
    end

    // Purpose: capture a host write to the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl <= '0;
        else if (we && addr == A_CTL) begin
            ctl.alm_en[0]  <= wdata[CTL_EN_A];
            ctl.alm_en[1]  <= wdata[CTL_EN_B];
            ctl.pulse_mode <= wdata[CTL_PULSE];
            ctl.auto_clr   <= wdata[CTL_AUTOCL];
        end
    end

    // Purpose: decode a status write into a clear request (combinational).
    always_comb begin
        stat_wr   = we && (addr == A_STAT);
        stat_keep = wdata[N_ALM-1:0];
    end
endmodule

// File: rtl/alm_match.sv
// Module: alm_match
// Compares one alarm set against the current time. A field takes part only
// when bit 7 of its byte is set. A hit needs at least one field enabled,
// the master enable, and the qualified advance edge.
// Assumes: time fields are valid in the cycle of the advance edge.
module alm_match
    import alm_pkg::*;
#(
    parameter int N_FLD = NUM_FIELDS,
    parameter int FW    = FIELD_W
) (
    input  logic [N_FLD-1:0][7:0]    cfg,
    input  logic [N_FLD-1:0][FW-1:0] now,
    input  logic                     master_en,
    input  logic                     adv_rise,
    output logic                     hit
);
    logic [N_FLD-1:0] fld_on;
    logic [N_FLD-1:0] fld_ok;

    for (genvar f = 0; f < N_FLD; f++) begin : g_cmp
        // Purpose: per-field enable and equality test.
        always_comb begin
            fld_on[f] = cfg[f][7];
            fld_ok[f] = !cfg[f][7] || (cfg[f][FW-1:0] == now[f]);
        end
    end

    // Purpose: combine the field results into one qualified hit.
    always_comb begin
        hit = adv_rise && master_en && (|fld_on) && (&fld_ok);
    end
endmodule

// File: rtl/alm_flags.sv
// Module: alm_flags
// One sticky status flag per alarm. A hit sets the flag and has priority
// over every clear. A status write with a 0 bit clears that flag. The read-done
// strobe clears all flags when auto-clear is on.
// Assumes: rd_done is a single-cycle strobe.
module alm_flags
    import alm_pkg::*;
#(
    parameter int N_ALM = NUM_ALARMS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ALM-1:0] hit,
    input  logic             stat_wr,
    input  logic [N_ALM-1:0] stat_keep,
    input  logic             rd_done,
    input  logic             auto_clr,
    output logic [N_ALM-1:0] flags
);
    for (genvar a = 0; a < N_ALM; a++) begin : g_flag
        // Purpose: set on hit, else clear on status write 0 or auto-clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[a] <= 1'b0;
            else if (hit[a])
                flags[a] <= 1'b1;
            else if (stat_wr && !stat_keep[a])
                flags[a] <= 1'b0;
            else if (rd_done && auto_clr)
                flags[a] <= 1'b0;
        end
    end
endmodule

// File: rtl/alm_pulse.sv
// Module: alm_pulse
// Pulse timer for pulse mode. A trigger loads the full count (and restarts
// a running one). Each reference tick counts down by one. The pulse is
// active while the count is non-zero. Leaving pulse mode drops the count.
// Assumes: ref_tick is a single-cycle strobe slower than clk.
module alm_pulse #(
    parameter int TICKS = 250,
    localparam int CW   = $clog2(TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic          trig,
    input  logic          ref_tick,
    output logic [CW-1:0] cnt,
    output logic          active
);
    // Purpose: load, restart or count down the pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode)
            cnt <= '0;
        else if (trig)
            cnt <= CW'(TICKS);
        else if (ref_tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    // Purpose: pulse is active while the count is non-zero.
    always_comb active = (cnt != '0);
endmodule

// File: rtl/dual_alarm.sv
// Module: dual_alarm (top)
// Two field-masked calendar alarms sharing one active-low interrupt.
// The rising edge of tick_adv qualifies a comparison, so one time value gives
// at most one trigger per alarm. The mode bit selects a level interrupt
// (low while any flag is set) or a timed pulse per match.
// Assumes: cur_* are stable BCD values whenever tick_adv rises.
module dual_alarm
    import alm_pkg::*;
#(
    parameter int PULSE_TICKS = 250,
    localparam int CW         = $clog2(PULSE_TICKS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FIELD_W-1:0]  cur_sec,
    input  logic [FIELD_W-1:0]  cur_min,
    input  logic [FIELD_W-1:0]  cur_hour,
    input  logic [FIELD_W-1:0]  cur_date,
    input  logic [FIELD_W-1:0]  cur_month,
    input  logic [FIELD_W-1:0]  cur_wday,
    input  logic                tick_adv,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [7:0]          reg_wdata,
    input  logic                stat_rd_done,
    input  logic                ref_tick,
    output logic                flag_a,
    output logic                flag_b,
    output logic                irq_n
);
    logic [NUM_ALARMS-1:0][NUM_FIELDS-1:0][7:0] cfg;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0]         now;
    ctl_t                                       ctl;
    logic                                       stat_wr;
    logic [NUM_ALARMS-1:0]                      stat_keep;
    logic [NUM_ALARMS-1:0]                      hit;
    logic [NUM_ALARMS-1:0]                      flags;
    logic                                       tick_q;
    logic                                       adv_rise;
    logic [CW-1:0]                              pulse_cnt;
    logic                                       pulse_on;

    // Purpose: gather the time fields in alarm byte order.
    always_comb begin
        now[FLD_SEC]   = cur_sec;
        now[FLD_MIN]   = cur_min;
        now[FLD_HOUR]  = cur_hour;
        now[FLD_DATE]  = cur_date;
        now[FLD_MONTH] = cur_month;
        now[FLD_WDAY]  = cur_wday;
    end

    // Purpose: remember the advance strobe for edge qualification.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_q <= 1'b0;
        else
            tick_q <= tick_adv;
    end

    // Purpose: one-cycle advance edge.
    always_comb adv_rise = tick_adv && !tick_q;

    alm_regs #(
        .N_ALM (NUM_ALARMS),
        .N_FLD (NUM_FIELDS),
        .AW    (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .cfg       (cfg),
        .ctl       (ctl),
        .stat_wr   (stat_wr),
        .stat_keep (stat_keep)
    );

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_match
        alm_match #(
            .N_FLD (NUM_FIELDS),
            .FW    (FIELD_W)
        ) u_match (
            .cfg       (cfg[a]),
            .now       (now),
            .master_en (ctl.alm_en[a]),
            .adv_rise  (adv_rise),
            .hit       (hit[a])
        );
    end

    alm_flags #(
        .N_ALM (NUM_ALARMS)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .stat_wr   (stat_wr),
        .stat_keep (stat_keep),
        .rd_done   (stat_rd_done),
        .auto_clr  (ctl.auto_clr),
        .flags     (flags)
    );

    alm_pulse #(
        .TICKS (PULSE_TICKS)
    ) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (ctl.pulse_mode),
        .trig     (|hit),
        .ref_tick (ref_tick),
        .cnt      (pulse_cnt),
        .active   (pulse_on)
    );

    // Purpose: drive the flags and pick the interrupt source by mode.
    always_comb begin
        flag_a = flags[0];
        flag_b = flags[1];
        irq_n  = ctl.pulse_mode ? !pulse_on : !(|flags);
    end
endmodule

// File: rtl/dual_alarm_chk.sv
// Module: dual_alarm_chk
// Checker bound into dual_alarm. It watches the hits, flags, pulse count and
// interrupt. Assumes single-cycle stat_rd_done and no mode change in the
// cycle of a hit.
module dual_alarm_chk #(
    parameter int PULSE_TICKS = 250,
    localparam int CW         = $clog2(PULSE_TICKS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    hit,
    input logic [1:0]    flags,
    input logic [1:0]    alm_en,
    input logic          pulse_mode,
    input logic          auto_clr,
    input logic          stat_rd_done,
    input logic [CW-1:0] pulse_cnt,
    input logic          irq_n
);
    p_hit_sets_flag_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> flags[0]);
    p_hit_sets_flag_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] |=> flags[1]);
    p_enable_gates_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(alm_en[0]));
    p_enable_gates_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(alm_en[1]));
    p_one_shot_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> !hit[0]);
    p_one_shot_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] |=> !hit[1]);
    p_no_host_set_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[0] && !hit[0]) |=> !flags[0]);
    p_no_host_set_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[1] && !hit[1]) |=> !flags[1]);
    p_level_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && (|flags)) |-> !irq_n);
    p_pulse_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= CW'(PULSE_TICKS));
    p_pulse_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && (|hit)) |=> (!irq_n || !pulse_mode));
    p_autoclr_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_clr && stat_rd_done && !hit[0]) |=> !flags[0]);
    p_autoclr_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_clr && stat_rd_done && !hit[1]) |=> !flags[1]);
    p_read_keeps_new_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_done && hit[0]) |=> flags[0]);
endmodule

bind dual_alarm dual_alarm_chk #(.PULSE_TICKS(PULSE_TICKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit          (hit),
    .flags        (flags),
    .alm_en       (ctl.alm_en),
    .pulse_mode   (ctl.pulse_mode),
    .auto_clr     (ctl.auto_clr),
    .stat_rd_done (stat_rd_done),
    .pulse_cnt    (pulse_cnt),
    .irq_n        (irq_n)
);

// File: tb/sim_dual_alarm.sv
// Directed bench for dual_alarm: one task per scenario, each checking its
// own results at the falling clock edge.
module sim_dual_alarm;
    localparam int CLK_PERIOD = 10;
    localparam int PT         = 6;
    localparam logic [4:0] A_CTL  = 5'd16;
    localparam logic [4:0] A_STAT = 5'd17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
    logic [6:0] cur_date = 7'h01, cur_month = 7'h01, cur_wday = '0;
    logic       tick_adv = 1'b0;
    logic       reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       stat_rd_done = 1'b0;
    logic       ref_tick = 1'b0;
    logic       flag_a, flag_b, irq_n;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_alarm #(.PULSE_TICKS(PT)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_date(cur_date), .cur_month(cur_month), .cur_wday(cur_wday),
        .tick_adv(tick_adv), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .stat_rd_done(stat_rd_done),
        .ref_tick(ref_tick), .flag_a(flag_a), .flag_b(flag_b), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic adv(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h,
                       input logic [6:0] d, input logic [6:0] mo, input logic [6:0] w);
        @(negedge clk);
        cur_sec = s; cur_min = m; cur_hour = h;
        cur_date = d; cur_month = mo; cur_wday = w;
        tick_adv = 1'b1;
        @(negedge clk);
        tick_adv = 1'b0;
    endtask

    task automatic rd_done();
        @(negedge clk);
        stat_rd_done = 1'b1;
        @(negedge clk);
        stat_rd_done = 1'b0;
    endtask

    task automatic rticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R1 flag_a", flag_a, 1'b0);
        check("R1 flag_b", flag_b, 1'b0);
        check("R1 irq_n", irq_n, 1'b1);
        adv(7'h00, 7'h00, 7'h00, 7'h01, 7'h01, 7'h00);
        check("R1 no match from reset config", flag_a | flag_b, 1'b0);
    endtask

    task automatic t_basic();
        wr(5'd1, 8'hB0);            // alarm A minute 30
        wr(5'd2, 8'h91);            // alarm A hour 11
        wr(5'd13, 8'h83);           // alarm B weekday 3
        wr(A_CTL, 8'h01);           // enable A only, level mode
        adv(7'h59, 7'h29, 7'h11, 7'h05, 7'h06, 7'h02);
        check("R2 no match one second early", flag_a, 1'b0);
        adv(7'h00, 7'h30, 7'h11, 7'h05, 7'h06, 7'h02);
        check("R2 flag_a on match", flag_a, 1'b1);
        check("R8 irq_n low in level mode", irq_n, 1'b0);
        check("R13 flag_b untouched", flag_b, 1'b0);
        wr(A_STAT, 8'h03);
        check("R7 writing 1 keeps flag", flag_a, 1'b1);
        wr(A_STAT, 8'h02);
        check("R7 writing 0 clears flag", flag_a, 1'b0);
        check("R8 irq_n high when flags clear", irq_n, 1'b1);
    endtask

    task automatic t_masked();
        adv(7'h17, 7'h30, 7'h11, 7'h22, 7'h09, 7'h06);
        check("R3 disabled fields ignored", flag_a, 1'b1);
        wr(A_STAT, 8'h00);
    endtask

    task automatic t_no_fields();
        wr(5'd13, 8'h03);           // B weekday enable bit off: no field on
        wr(A_CTL, 8'h02);           // enable B only
        adv(7'h00, 7'h30, 7'h11, 7'h05, 7'h06, 7'h03);
        check("R4 no field enabled never matches", flag_b, 1'b0);
        wr(5'd13, 8'h83);
    endtask

    task automatic t_master_off();
        wr(A_CTL, 8'h00);
        adv(7'h00, 7'h30, 7'h11, 7'h05, 7'h06, 7'h03);
        check("R5 master off: flag_a", flag_a, 1'b0);
        check("R5 master off: flag_b", flag_b, 1'b0);
        check("R5 master off: irq_n", irq_n, 1'b1);
    endtask

    task automatic t_held_tick();
        wr(A_CTL, 8'h01);
        @(negedge clk);
        cur_sec = 7'h00; cur_min = 7'h30; cur_hour = 7'h11; cur_wday = 7'h01;
        tick_adv = 1'b1;
        @(negedge clk);
        check("R6 first edge triggers", flag_a, 1'b1);
        wr(A_STAT, 8'h00);
        repeat (3) @(negedge clk);
        check("R6 held tick does not retrigger", flag_a, 1'b0);
        tick_adv = 1'b0;
    endtask

    task automatic t_both();
        wr(A_CTL, 8'h03);
        adv(7'h00, 7'h30, 7'h11, 7'h05, 7'h06, 7'h03);
        check("R13 both match: flag_a", flag_a, 1'b1);
        check("R13 both match: flag_b", flag_b, 1'b1);
        wr(A_STAT, 8'h02);
        check("R8 irq_n low while flag_b set", irq_n, 1'b0);
        wr(A_STAT, 8'h00);
        check("R8 irq_n high after both clear", irq_n, 1'b1);
        adv(7'h00, 7'h31, 7'h11, 7'h05, 7'h06, 7'h03);
        check("R13 only B matches: flag_b", flag_b, 1'b1);
        check("R13 only B matches: flag_a", flag_a, 1'b0);
        wr(A_STAT, 8'h00);
    endtask

    task automatic t_autoclr();
        adv(7'h00, 7'h30, 7'h11, 7'h05, 7'h06, 7'h00);
        rd_done();
        check("R11 no auto-clear when off", flag_a, 1'b1);
        wr(A_CTL, 8'h0B);           // both enabled, auto-clear on
        rd_done();
        check("R11 auto-clear clears flag", flag_a, 1'b0);
        check("R11 irq_n released", irq_n, 1'b1);
    endtask

    task automatic t_read_race();
        adv(7'h00, 7'h31, 7'h11, 7'h05, 7'h06, 7'h03);
        check("R12 setup flag_b", flag_b, 1'b1);
        @(negedge clk);
        cur_min = 7'h30; cur_wday = 7'h04;
        tick_adv = 1'b1; stat_rd_done = 1'b1;
        @(negedge clk);
        tick_adv = 1'b0; stat_rd_done = 1'b0;
        check("R12 new flag survives read", flag_a, 1'b1);
        check("R11 old flag cleared by read", flag_b, 1'b0);
        wr(A_STAT, 8'h00);
        wr(A_CTL, 8'h00);
    endtask

    task automatic t_pulse();
        wr(A_CTL, 8'h05);           // A enabled, pulse mode
        adv(7'h00, 7'h30, 7'h11, 7'h05, 7'h06, 7'h00);
        check("R9 flag set in pulse mode", flag_a, 1'b1);
        check("R9 pulse starts", irq_n, 1'b0);
        rticks(PT - 1);
        check("R9 pulse still low before last tick", irq_n, 1'b0);
        rticks(1);
        check("R9 pulse ends after full count", irq_n, 1'b1);
        check("R9 flag stays set after pulse", flag_a, 1'b1);
    endtask

    task automatic t_retrigger();
        adv(7'h01, 7'h30, 7'h11, 7'h05, 7'h06, 7'h00);
        rticks(3);
        adv(7'h02, 7'h30, 7'h11, 7'h05, 7'h06, 7'h00);
        rticks(PT - 1);
        check("R10 restarted pulse still low", irq_n, 1'b0);
        rticks(1);
        check("R10 restarted pulse ends", irq_n, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_masked();
        t_no_fields();
        t_master_off();
        t_held_tick();
        t_both();
        t_autoclr();
        t_read_race();
        t_pulse();
        t_retrigger();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule